// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block holds a wall-clock time and calendar (seconds, minutes, hours, day of week, day of month, month and two-digit year), each in its own byte. Each field is kept in BCD or plain binary, and hours in 12-hour or 24-hour form. The active format is set by a control byte. Software reaches every byte by index through a request/response register port.

Once per second a tick input starts an update sequence. A busy flag rises first. After a fixed number of time-base pulses the whole calendar advances by one second, with every carry and month length applied. The busy flag is held for a further fixed number of time-base pulses. It then drops and an update-ended flag is latched. Software that wants a consistent snapshot waits for the busy flag to be clear, or for the ended flag. To load a new time it sets a hold bit, writes the fields, and releases the hold.

The request channel follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` drops while a read response is waiting and `rsp_ready` is low. A read response stays on `rsp_valid`/`rsp_rdata`, unchanged, until a cycle with `rsp_ready` high. Writes produce no response.

Top module: `bcd_tod_rtc`

## Requirements
- R1: After reset, the index map reads as follows: seconds (index 0) 0x00, minutes (2) 0x00, hours (4) 0x00, weekday (6) 0x01, day of month (7) 0x01, month (8) 0x01, year (9) 0x00, status (10) 0x00, mode (11) 0x02 and event (12) 0x00.
- R2: Bit 2 of the mode byte selects the encoding: clear means BCD, set means plain binary. In BCD, a units digit of 9 carries into the tens digit (0x09 becomes 0x10).
- R3: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the day. Weekday counts 1 to 7 and wraps from 7 to 1.
- R4: Day of month wraps to 1 after the last day of its month. Months 4, 6, 9 and 11 have 30 days, month 2 has 29 days when the year is divisible by 4 and 28 days otherwise, and all other months have 31. Month wraps from 12 to 1 and carries into the year. Year wraps from 99 to 0.
- R5: Bit 1 of the mode byte set selects 24-hour hours (0-23). Clear selects 12-hour hours (1-12), with bit 7 of the hour byte as the PM flag. Midnight is 12 with PM clear, and noon is 12 with PM set.
- R6: Bit 7 of the status byte (index 10) reads 1 from the cycle after an accepted second tick until the update ends. The time bytes change on the LEAD_TICKS-th time-base pulse after the tick. The flag stays set for UPD_TICKS more pulses. Second ticks that arrive while the flag is set are ignored.
- R7: While bit 7 of the mode byte (index 11) is set, second ticks are ignored and a pending update is dropped. The time bytes still accept writes.
- R8: Bit 4 of the event byte (index 12) sets when an update ends. A read of index 12 returns it and clears it.
- R9: A read response is held stable until it is accepted, and no request is taken while a response waits. Writes to the status byte are ignored. Reads of unmapped indices return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Single-cycle time-base pulse (32768 Hz rate) |
| sec_tick | input | 1 | Single-cycle once-per-second pulse |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | IDX_W | Byte index |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_rdata | output | 8 | Read data |

## Verification
The assertions assume that `tb_tick` and `sec_tick` are single-cycle pulses, that `rst_n` is applied at the start, and that the response consumer may stall for any number of cycles. The bench produces time-base pulses every fourth cycle. It pulses the second tick only from an idle state, and it waits long enough for a full update to finish. The calendar values it writes are always legal for the selected encoding and hour mode. It stalls `rsp_ready` on a repeating pattern so that the hold rules of the response channel are exercised throughout.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] year;
  } tod_t;

  localparam int RTC_IDX_SEC  = 0;
  localparam int RTC_IDX_MIN  = 2;
  localparam int RTC_IDX_HOUR = 4;
  localparam int RTC_IDX_WDAY = 6;
  localparam int RTC_IDX_MDAY = 7;
  localparam int RTC_IDX_MON  = 8;
  localparam int RTC_IDX_YEAR = 9;
  localparam int RTC_IDX_STAT = 10;
  localparam int RTC_IDX_MODE = 11;
  localparam int RTC_IDX_EVT  = 12;

  // field byte -> binary value
  function automatic logic [6:0] fld_decode(input logic [7:0] v, input logic bin);
    if (bin) return v[6:0];
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // binary value -> field byte
  function automatic logic [7:0] fld_encode(input logic [6:0] n, input logic bin);
    if (bin) return {1'b0, n};
    return {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction

  // hour byte -> 0..23
  function automatic logic [6:0] hour_decode(input logic [7:0] h, input logic bin,
                                             input logic m24);
    logic [6:0] v;
    v = fld_decode({1'b0, h[6:0]}, bin);
    if (m24) return v;
    if (v == 7'd12) return h[7] ? 7'd12 : 7'd0;
    return h[7] ? v + 7'd12 : v;
  endfunction

  // 0..23 -> hour byte
  function automatic logic [7:0] hour_encode(input logic [6:0] h24, input logic bin,
                                             input logic m24);
    logic       pm;
    logic [6:0] h12;
    logic [7:0] e;
    if (m24) return fld_encode(h24, bin);
    pm  = (h24 >= 7'd12);
    h12 = pm ? h24 - 7'd12 : h24;
    if (h12 == 7'd0) h12 = 7'd12;
    e = fld_encode(h12, bin);
    return {pm, e[6:0]};
  endfunction

  function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd2:                       return (yr[1:0] == 2'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
  parameter int LEAD_TICKS = 8,
  parameter int UPD_TICKS  = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tb_tick,
  input  logic sec_tick,
  input  logic freeze,
  output logic uip,
  output logic step,
  output logic done
);
  localparam int MAXT = (LEAD_TICKS > UPD_TICKS) ? LEAD_TICKS : UPD_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_TICKS - 1);
  localparam logic [CW-1:0] UPD_LAST  = CW'(UPD_TICKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_POST} seq_state_t;

  seq_state_t    state_q;
  logic [CW-1:0] cnt_q;

  assign uip  = (state_q != S_IDLE);
  assign step = (state_q == S_LEAD) && !freeze && tb_tick && (cnt_q == LEAD_LAST);
  assign done = (state_q == S_POST) && tb_tick && (cnt_q == UPD_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (sec_tick && !freeze) begin
            state_q <= S_LEAD;
            cnt_q   <= '0;
          end
        end
        S_LEAD: begin
          if (freeze) begin
            state_q <= S_IDLE;
          end else if (tb_tick) begin
            if (cnt_q == LEAD_LAST) begin
              state_q <= S_POST;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        S_POST: begin
          if (tb_tick) begin
            if (cnt_q == UPD_LAST) state_q <= S_IDLE;
            else                   cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_pkg::*;
(
  input  tod_t cur,
  input  logic bin,
  input  logic m24,
  output tod_t nxt
);
  logic [6:0] s, m, h, w, d, mo, y, mlen;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    nxt = cur;
    s  = fld_decode(cur.sec, bin);
    m  = fld_decode(cur.min, bin);
    h  = hour_decode(cur.hour, bin, m24);
    w  = fld_decode(cur.wday, bin);
    d  = fld_decode(cur.mday, bin);
    mo = fld_decode(cur.mon, bin);
    y  = fld_decode(cur.year, bin);
    mlen = month_days(mo, y);

    c_min = (s >= 7'd59);
    nxt.sec = fld_encode(c_min ? 7'd0 : s + 7'd1, bin);

    c_hr = 1'b0;
    if (c_min) begin
      c_hr = (m >= 7'd59);
      nxt.min = fld_encode(c_hr ? 7'd0 : m + 7'd1, bin);
    end

    c_day = 1'b0;
    if (c_hr) begin
      c_day = (h >= 7'd23);
      nxt.hour = hour_encode(c_day ? 7'd0 : h + 7'd1, bin, m24);
    end

    c_mon = 1'b0;
    if (c_day) begin
      nxt.wday = fld_encode((w >= 7'd7) ? 7'd1 : w + 7'd1, bin);
      c_mon = (d >= mlen);
      nxt.mday = fld_encode(c_mon ? 7'd1 : d + 7'd1, bin);
    end

    c_yr = 1'b0;
    if (c_mon) begin
      c_yr = (mo >= 7'd12);
      nxt.mon = fld_encode(c_yr ? 7'd1 : mo + 7'd1, bin);
    end

    if (c_yr) begin
      nxt.year = fld_encode((y >= 7'd99) ? 7'd0 : y + 7'd1, bin);
    end
  end
endmodule

// File: rtl/bcd_tod_rtc.sv
module bcd_tod_rtc
  import rtc_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int LEAD_TICKS = 8,
  parameter int UPD_TICKS  = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_tick,
  input  logic             sec_tick,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_index,
  input  logic [7:0]       req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_rdata
);
  tod_t tod_q, tod_next;
  logic ctl_freeze, ctl_bin, ctl_m24;
  logic flag_uf;
  logic seq_uip, seq_step, seq_done;
  logic req_fire, wr_fire, rd_fire;
  logic [7:0] rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign wr_fire   = req_fire && req_write;
  assign rd_fire   = req_fire && !req_write;

  rtc_upd_seq #(.LEAD_TICKS(LEAD_TICKS), .UPD_TICKS(UPD_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .sec_tick(sec_tick),
    .freeze(ctl_freeze), .uip(seq_uip), .step(seq_step), .done(seq_done)
  );

  rtc_cal_step u_step (
    .cur(tod_q), .bin(ctl_bin), .m24(ctl_m24), .nxt(tod_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod_q      <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                      mday: 8'h01, mon: 8'h01, year: 8'h00};
      ctl_freeze <= 1'b0;
      ctl_bin    <= 1'b0;
      ctl_m24    <= 1'b1;
    end else begin
      if (seq_step) tod_q <= tod_next;
      if (wr_fire) begin
        case (req_index)
          IDX_W'(RTC_IDX_SEC):  tod_q.sec  <= req_wdata;
          IDX_W'(RTC_IDX_MIN):  tod_q.min  <= req_wdata;
          IDX_W'(RTC_IDX_HOUR): tod_q.hour <= req_wdata;
          IDX_W'(RTC_IDX_WDAY): tod_q.wday <= req_wdata;
          IDX_W'(RTC_IDX_MDAY): tod_q.mday <= req_wdata;
          IDX_W'(RTC_IDX_MON):  tod_q.mon  <= req_wdata;
          IDX_W'(RTC_IDX_YEAR): tod_q.year <= req_wdata;
          IDX_W'(RTC_IDX_MODE): begin
            ctl_freeze <= req_wdata[7];
            ctl_bin    <= req_wdata[2];
            ctl_m24    <= req_wdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  // update-ended flag: a new event wins over a clearing read
  always_ff @(posedge clk) begin
    if (!rst_n) flag_uf <= 1'b0;
    else if (seq_done) flag_uf <= 1'b1;
    else if (rd_fire && req_index == IDX_W'(RTC_IDX_EVT)) flag_uf <= 1'b0;
  end

  always_comb begin
    case (req_index)
      IDX_W'(RTC_IDX_SEC):  rd_mux = tod_q.sec;
      IDX_W'(RTC_IDX_MIN):  rd_mux = tod_q.min;
      IDX_W'(RTC_IDX_HOUR): rd_mux = tod_q.hour;
      IDX_W'(RTC_IDX_WDAY): rd_mux = tod_q.wday;
      IDX_W'(RTC_IDX_MDAY): rd_mux = tod_q.mday;
      IDX_W'(RTC_IDX_MON):  rd_mux = tod_q.mon;
      IDX_W'(RTC_IDX_YEAR): rd_mux = tod_q.year;
      IDX_W'(RTC_IDX_STAT): rd_mux = {seq_uip, 7'b0};
      IDX_W'(RTC_IDX_MODE): rd_mux = {ctl_freeze, 4'b0, ctl_bin, ctl_m24, 1'b0};
      IDX_W'(RTC_IDX_EVT):  rd_mux = {3'b0, flag_uf, 4'b0};
      default:              rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 8'h00;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       uip,
  input logic       step,
  input logic       done,
  input logic       freeze,
  input logic       uf,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_rdata
);
  p_step_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> uip);
  p_flag_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !uip);
  p_single_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step, done}));
  p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !step);
  p_ended_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> uf);
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  p_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind bcd_tod_rtc rtc_checker u_rtc_chk (
  .clk(clk), .rst_n(rst_n), .uip(seq_uip), .step(seq_step), .done(seq_done),
  .freeze(ctl_freeze), .uf(flag_uf), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
);

// File: tb/bcd_tod_rtc_test.sv
module bcd_tod_rtc_test;
  localparam int IDX_W = 4;
  localparam int LEAD  = 4;
  localparam int UPD   = 3;
  localparam int TBDIV = 4;
  localparam int SETTLE = (LEAD + UPD + 3) * TBDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_tick = 1'b0, sec_tick = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [IDX_W-1:0] req_index = '0;
  logic [7:0] req_wdata = 8'h00;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  bcd_tod_rtc #(.IDX_W(IDX_W), .LEAD_TICKS(LEAD), .UPD_TICKS(UPD)) uut (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .sec_tick(sec_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  // free-running time base
  int tb_cnt = 0;
  always @(negedge clk) begin
    tb_tick <= (tb_cnt == 0);
    tb_cnt  <= (tb_cnt == TBDIV - 1) ? 0 : tb_cnt + 1;
  end

  // monitor: stall pattern, then score each accepted response
  int bp = 0;
  always @(negedge clk) begin
    bp = bp + 1;
    rsp_ready = (bp % 7) != 3 && (bp % 7) != 4;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected response actual %02h expected none", rsp_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rsp_rdata !== e) begin
          errors++;
          $display("FAIL %s actual %02h expected %02h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic issue(input logic wr, input int idx, input logic [7:0] d);
    forever begin
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_index = IDX_W'(idx); req_wdata = d;
      #1;
      if (req_ready) begin
        @(posedge clk);
        break;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    issue(1'b1, idx, d);
  endtask

  task automatic rd(input int idx, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    issue(1'b0, idx, 8'h00);
  endtask

  task automatic load_time(input logic [7:0] mode, input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] w, input logic [7:0] d,
                           input logic [7:0] mo, input logic [7:0] y);
    wr(11, mode | 8'h80);
    wr(0, s); wr(2, m); wr(4, h); wr(6, w); wr(7, d); wr(8, mo); wr(9, y);
    wr(11, mode);
  endtask

  task automatic one_second();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(0, 8'h00, "R1 sec"); rd(2, 8'h00, "R1 min"); rd(4, 8'h00, "R1 hour");
    rd(6, 8'h01, "R1 wday"); rd(7, 8'h01, "R1 mday"); rd(8, 8'h01, "R1 mon");
    rd(9, 8'h00, "R1 year"); rd(10, 8'h00, "R1 stat"); rd(11, 8'h02, "R1 mode");
    rd(12, 8'h00, "R1 evt");

    // R9 unmapped index and ignored status write
    rd(1, 8'h00, "R9 unmapped");
    wr(10, 8'h7F);
    rd(10, 8'h00, "R9 status write ignored");

    // R2 BCD digit carry
    load_time(8'h02, 8'h09, 8'h15, 8'h10, 8'h03, 8'h10, 8'h05, 8'h20);
    one_second();
    rd(0, 8'h10, "R2 bcd carry");

    // R6 early flag and unchanged bytes, then completion; R8 event flag
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    rd(10, 8'h80, "R6 flag raised");
    rd(0, 8'h10, "R6 bytes unchanged during lead");
    repeat (SETTLE) @(negedge clk);
    rd(0, 8'h11, "R6 bytes advanced");
    rd(10, 8'h00, "R6 flag cleared");
    rd(12, 8'h10, "R8 ended set");
    rd(12, 8'h00, "R8 cleared by read");

    // R3 R4 full BCD rollover 99-12-31 23:59:59, weekday 7
    load_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    one_second();
    rd(0, 8'h00, "R3 sec wrap"); rd(2, 8'h00, "R3 min wrap"); rd(4, 8'h00, "R3 hour wrap");
    rd(6, 8'h01, "R3 wday wrap"); rd(7, 8'h01, "R4 mday wrap");
    rd(8, 8'h01, "R4 mon wrap"); rd(9, 8'h00, "R4 year wrap");

    // R2 R4 binary mode, non-leap February 28
    load_time(8'h06, 8'h3B, 8'h3B, 8'h17, 8'h02, 8'h1C, 8'h02, 8'h01);
    one_second();
    rd(0, 8'h00, "R2 bin sec"); rd(4, 8'h00, "R2 bin hour");
    rd(7, 8'h01, "R4 feb28 nonleap"); rd(8, 8'h03, "R4 feb to mar");
    rd(11, 8'h06, "R2 mode readback");

    // R4 leap year
    load_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    one_second();
    rd(7, 8'h29, "R4 leap feb29"); rd(8, 8'h02, "R4 leap stays feb");
    load_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    one_second();
    rd(7, 8'h01, "R4 leap feb29 wrap"); rd(8, 8'h03, "R4 leap to mar");

    // R4 thirty-day month
    load_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
    one_second();
    rd(7, 8'h01, "R4 apr30 wrap"); rd(8, 8'h05, "R4 apr to may");

    // R5 12-hour mode (BCD)
    load_time(8'h00, 8'h59, 8'h59, 8'h11, 8'h02, 8'h05, 8'h06, 8'h10);
    one_second();
    rd(4, 8'h92, "R5 11am to noon");
    load_time(8'h00, 8'h59, 8'h59, 8'h92, 8'h02, 8'h05, 8'h06, 8'h10);
    one_second();
    rd(4, 8'h81, "R5 noon to 1pm");
    load_time(8'h00, 8'h59, 8'h59, 8'h91, 8'h02, 8'h05, 8'h06, 8'h10);
    one_second();
    rd(4, 8'h12, "R5 11pm to midnight"); rd(7, 8'h06, "R5 midnight day carry");
    load_time(8'h00, 8'h59, 8'h59, 8'h12, 8'h02, 8'h05, 8'h06, 8'h10);
    one_second();
    rd(4, 8'h01, "R5 midnight to 1am");

    // R7 hold: tick ignored, writes accepted, no ended event
    rd(12, 8'h10, "R8 set before hold");
    wr(11, 8'h82);
    wr(0, 8'h42);
    one_second();
    rd(0, 8'h42, "R7 held no advance");
    rd(10, 8'h00, "R7 no flag while held");
    rd(12, 8'h00, "R7 no ended while held");
    wr(11, 8'h02);
    one_second();
    rd(0, 8'h43, "R7 resumes after release");

    begin : drain
      int n = 0;
      while (exp_q.size() != 0 && n < 1000) begin
        @(negedge clk);
        n++;
      end
      if (exp_q.size() != 0) begin
        errors++;
        $display("FAIL R9 responses missing actual %0d expected 0", exp_q.size());
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule